// File: doc/BRIEF.md
# Video Memory Block-Transfer Engine

This block moves blocks of 16-bit words into the video RAM of a display processor without host intervention. It holds its own copies of the transfer registers: a 16-bit word count, a 16-bit source pointer and a type byte. It also holds the destination step and the engine enable bit. A register write port loads all of these. A memory command arrives with its "transfer" code bit set and carries the 16-bit destination address. If the engine is enabled, that command starts a transfer.

The top two bits of the type byte select one of three modes. In host-copy mode the engine fetches words from the host bus and writes each one into video RAM. The low seven bits of the type byte extend the pointer to a 23-bit word address, and the bus sees that address doubled. In fill mode the engine waits for the next data-port write and repeats that word across the whole count. In internal-copy mode the engine reads video RAM at the pointer and writes the word back at the destination. Each beat advances the destination by the step value and the pointer by one, and counts the length down. A busy flag stays high from start to the last write.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset, `busy`, `host_req` and `vram_req` are low, and `len_rd` and `src_rd` read zero.
- R2: A register write with `reg_sel` of 0x13 or 0x14 loads the low or high byte of the count. Writes to 0x15 and 0x16 load the low and middle bytes of the pointer. A write to 0x17 loads the type byte, 0x0F loads the destination step, and bit 4 of a write to 0x01 is the enable. `len_rd` shows the count, and `src_rd` shows {type[6:0], pointer[15:0]}.
- R3: A transfer starts when the engine is idle and enabled and `cmd_valid` is high with `cmd_code[5]` set, and `busy` rises on the next cycle. Without the enable, or without code bit 5, nothing happens.
- R4: With type bit 7 clear (host copy), each beat holds `host_req` with `host_addr` = {type[6:0], pointer} shifted left by one until `host_valid`. It then makes one video RAM write of `host_rdata`, and the two requests never overlap.
- R5: With type bits 7..6 = 10 (fill), the engine makes no access until a `data_we` pulse. It then writes `data_wdata` to every destination of the transfer.
- R6: With type bits 7..6 = 11 (internal copy), each beat reads video RAM at the 16-bit pointer. The next cycle writes the returned `vram_rdata` to the destination, and read data arrives one cycle after the read request.
- R7: The first write goes to the command address, and each later write goes to the previous one plus the step, modulo 2^16. The pointer advances by one per beat: across all 23 bits in host copy, and across the low 16 bits otherwise, with the type byte unchanged.
- R8: A count of zero performs 65536 writes.
- R9: `busy` stays high through the whole transfer, including the wait for fill data. No request is raised while `busy` is low.
- R10: When `busy` falls, `len_rd` is zero and `src_rd` holds the pointer after the last word.
- R11: While `busy` is high, register writes to 0x0F and 0x13 to 0x17 are ignored, and so are new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register index |
| reg_wdata | input | 8 | Register write data |
| cmd_valid | input | 1 | Memory command strobe |
| cmd_code | input | 6 | Command code; bit 5 requests a transfer |
| cmd_addr | input | 16 | Destination word address |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port write word |
| host_req | output | 1 | Host read request |
| host_addr | output | 24 | Host byte address |
| host_valid | input | 1 | Host read data valid |
| host_rdata | input | 16 | Host read data |
| vram_req | output | 1 | Video RAM access request |
| vram_we | output | 1 | Video RAM write (1) or read (0) |
| vram_addr | output | 16 | Video RAM word address |
| vram_wdata | output | 16 | Video RAM write data |
| vram_rdata | input | 16 | Video RAM read data, one cycle after a read |
| busy | output | 1 | Transfer in progress |
| len_rd | output | 16 | Current count |
| src_rd | output | 23 | Current pointer with type bits 6..0 on top |

## Verification
Each of the three modes runs with random counts, pointers, destinations and steps, including a step of zero. Host-copy runs add random response delays, which separates correct request holding and word-address doubling from an engine that ignores the handshake. Fill runs insert an idle gap and busy-time register and command writes before the data word, which exposes early writes and missing register locks. A directed zero count shows whether the count is treated as 65536 or as nothing, and a pointer near the 16-bit boundary shows whether the type bits join the carry only in host copy.

// File: rtl/vram_dma_engine.sv
module vram_dma_engine #(
  parameter int DW  = 16,
  parameter int VAW = 16,
  parameter int HAW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [4:0]     reg_sel,
  input  logic [7:0]     reg_wdata,
  input  logic           cmd_valid,
  input  logic [5:0]     cmd_code,
  input  logic [VAW-1:0] cmd_addr,
  input  logic           data_we,
  input  logic [DW-1:0]  data_wdata,
  output logic           host_req,
  output logic [HAW-1:0] host_addr,
  input  logic           host_valid,
  input  logic [DW-1:0]  host_rdata,
  output logic           vram_req,
  output logic           vram_we,
  output logic [VAW-1:0] vram_addr,
  output logic [DW-1:0]  vram_wdata,
  input  logic [DW-1:0]  vram_rdata,
  output logic           busy,
  output logic [15:0]    len_rd,
  output logic [HAW-2:0] src_rd
);
  localparam int SW = HAW - 1;
  localparam logic [4:0] SEL_MODE2 = 5'h01;
  localparam logic [4:0] SEL_STEP  = 5'h0F;
  localparam logic [4:0] SEL_LENL  = 5'h13;
  localparam logic [4:0] SEL_LENH  = 5'h14;
  localparam logic [4:0] SEL_SRCL  = 5'h15;
  localparam logic [4:0] SEL_SRCM  = 5'h16;
  localparam logic [4:0] SEL_TYPE  = 5'h17;

  typedef enum logic [2:0] {S_IDLE, S_HREQ, S_HWR, S_FWAIT, S_FWR, S_CRD, S_CWR} st_t;

  st_t            st;
  logic           en;
  logic [7:0]     step;
  logic [15:0]    len;
  logic [15:0]    ptr;
  logic [7:0]     typ;
  logic [VAW-1:0] dst;
  logic [DW-1:0]  dat;

  wire start    = (st == S_IDLE) && en && cmd_valid && cmd_code[5];
  wire beat     = (st == S_HWR) || (st == S_FWR) || (st == S_CWR);
  wire last     = (len == 16'd1);
  wire [SW-1:0] full_src = {typ[SW-17:0], ptr};
  wire [SW-1:0] full_nxt = full_src + 1'b1;

  assign busy       = (st != S_IDLE);
  assign host_req   = (st == S_HREQ);
  assign host_addr  = {full_src, 1'b0};
  assign vram_req   = beat || (st == S_CRD);
  assign vram_we    = beat;
  assign vram_addr  = (st == S_CRD) ? ptr[VAW-1:0] : dst;
  assign vram_wdata = (st == S_CWR) ? vram_rdata : dat;
  assign len_rd     = len;
  assign src_rd     = full_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      en   <= 1'b0;
      step <= '0;
      len  <= '0;
      ptr  <= '0;
      typ  <= '0;
      dst  <= '0;
      dat  <= '0;
    end else begin
      if (reg_we) begin
        if (reg_sel == SEL_MODE2) en <= reg_wdata[4];
        if (st == S_IDLE) begin
          case (reg_sel)
            SEL_STEP: step       <= reg_wdata;
            SEL_LENL: len[7:0]   <= reg_wdata;
            SEL_LENH: len[15:8]  <= reg_wdata;
            SEL_SRCL: ptr[7:0]   <= reg_wdata;
            SEL_SRCM: ptr[15:8]  <= reg_wdata;
            SEL_TYPE: typ        <= reg_wdata;
            default: ;
          endcase
        end
      end
      if (beat) begin
        len <= len - 1'b1;
        dst <= dst + VAW'(step);
        if (typ[7]) ptr <= ptr + 1'b1;
        else {typ[SW-17:0], ptr} <= full_nxt;
      end
      case (st)
        S_IDLE: if (start) begin
          dst <= cmd_addr;
          if (!typ[7])     st <= S_HREQ;
          else if (typ[6]) st <= S_CRD;
          else             st <= S_FWAIT;
        end
        S_HREQ: if (host_valid) begin
          dat <= host_rdata;
          st  <= S_HWR;
        end
        S_HWR:   st <= last ? S_IDLE : S_HREQ;
        S_FWAIT: if (data_we) begin
          dat <= data_wdata;
          st  <= S_FWR;
        end
        S_FWR:   if (last) st <= S_IDLE;
        S_CRD:   st <= S_CWR;
        S_CWR:   st <= last ? S_IDLE : S_CRD;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vram_dma_engine_chk.sv
module vram_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        cmd_valid,
  input logic [5:0]  cmd_code,
  input logic        host_req,
  input logic [23:0] host_addr,
  input logic        host_valid,
  input logic        vram_req,
  input logic        busy,
  input logic [15:0] len_rd
);
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vram_req && !host_req)); // R9
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && vram_req)); // R4
  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_valid) |=> (host_req && $stable(host_addr))); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en && cmd_valid && cmd_code[5]) |=> busy); // R3
  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(en && cmd_valid && cmd_code[5])) |=> !busy); // R3
  AST_END_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_rd == 16'd0)); // R10
endmodule

bind vram_dma_engine vram_dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .host_req(host_req), .host_addr(host_addr), .host_valid(host_valid),
  .vram_req(vram_req), .busy(busy), .len_rd(len_rd)
);

// File: tb/test_vram_dma_engine.sv
module test_vram_dma_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [5:0]  cmd_code = '0;
  logic [15:0] cmd_addr = '0;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = '0;
  logic        host_req;
  logic [23:0] host_addr;
  logic        host_valid = 1'b0;
  logic [15:0] host_rdata = '0;
  logic        vram_req, vram_we;
  logic [15:0] vram_addr, vram_wdata;
  logic [15:0] vram_rdata = '0;
  logic        busy;
  logic [15:0] len_rd;
  logic [22:0] src_rd;

  vram_dma_engine i_vram_dma_engine (.*);

  int n_cmp = 0, n_bad = 0;
  logic [15:0] mem [0:65535];
  logic [15:0] rd_next = '0;

  int          e_mode;
  int          e_len, wr_idx, rd_idx;
  logic [22:0] e_src;
  logic [15:0] e_dst;
  logic [7:0]  e_step;
  logic [15:0] e_fill;

  function automatic logic [15:0] init_fn(input logic [15:0] a);
    return (a * 16'd7) ^ 16'h3C5A;
  endfunction
  function automatic logic [15:0] host_fn(input logic [23:0] a);
    return a[16:1] ^ {a[23:17], 9'h155};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = init_fn(16'(i));
    e_mode = -1; e_len = 0; wr_idx = 0; rd_idx = 0;
    e_src = '0; e_dst = '0; e_step = '0; e_fill = '0;
  end

  always @(negedge clk) begin
    if (rst_n && vram_req && !vram_we) rd_next <= mem[vram_addr];
    if (rst_n && vram_req && vram_we) begin
      logic [15:0] xd;
      if (e_mode == 0)      xd = host_fn({e_src + 23'(wr_idx), 1'b0});
      else if (e_mode == 1) xd = e_fill;
      else                  xd = init_fn(e_src[15:0] + 16'(wr_idx));
      if (wr_idx >= e_len) check("R3 unexpected write", 32'(wr_idx), 32'(e_len));
      else begin
        check("R7 write address", vram_addr, e_dst + 16'(wr_idx) * 16'(e_step));
        if (e_mode == 0)      check("R4 host word", vram_wdata, xd);
        else if (e_mode == 1) check("R5 fill word", vram_wdata, xd);
        else                  check("R6 copy word", vram_wdata, xd);
      end
      mem[vram_addr] = vram_wdata;
      wr_idx++;
    end
    if (rst_n && host_req && host_valid) begin
      check("R4 host address", host_addr, {e_src + 23'(rd_idx), 1'b0});
      rd_idx++;
    end
  end

  initial forever begin
    @(posedge clk); #1;
    vram_rdata = rd_next;
    host_valid = 1'b0;
    if (host_req && ($urandom % 3 == 0)) begin
      host_valid = 1'b1;
      host_rdata = host_fn(host_addr);
    end
  end

  task automatic wreg(input logic [4:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic cmd(input logic [5:0] c, input logic [15:0] a);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic run(input int mode, input logic [15:0] len, input logic [22:0] src,
                     input logic [15:0] dst, input logic [7:0] step, input logic [15:0] fillv,
                     input bit poke);
    logic [7:0]  typ;
    logic [22:0] end_src;
    int n = (len == 0) ? 65536 : int'(len);
    typ = (mode == 0) ? {1'b0, src[22:16]} : {mode == 2, 6'(src[21:16])};
    typ[7] = (mode != 0);
    wreg(5'h0F, step); wreg(5'h13, len[7:0]); wreg(5'h14, len[15:8]);
    wreg(5'h15, src[7:0]); wreg(5'h16, src[15:8]); wreg(5'h17, typ);
    check("R2 count readback", len_rd, len);
    check("R2 pointer readback", src_rd, {typ[6:0], src[15:0]});
    e_mode = mode; e_len = n; e_src = (mode == 0) ? src : {7'd0, src[15:0]};
    e_dst = dst; e_step = step; e_fill = fillv; wr_idx = 0; rd_idx = 0;
    cmd(6'h21, dst);
    check("R9 busy after start", busy, 1'b1);
    if (mode == 1) begin
      repeat (4) @(posedge clk);
      #1;
      check("R5 no write before data", 32'(wr_idx), 0);
      check("R9 busy during fill wait", busy, 1'b1);
      if (poke) begin
        wreg(5'h13, 8'h55); wreg(5'h0F, 8'h09);
        cmd(6'h21, 16'h1234);
        check("R11 count locked", len_rd, len);
      end
      @(posedge clk); #1;
      data_we = 1'b1; data_wdata = fillv;
      @(posedge clk); #1;
      data_we = 1'b0;
    end
    while (busy) @(posedge clk);
    @(negedge clk);
    end_src = (mode == 0) ? src + 23'(n) : {typ[6:0], src[15:0] + 16'(n)};
    if (len == 0) check("R8 zero count writes", 32'(wr_idx), 32'd65536);
    else          check("R7 write count", 32'(wr_idx), 32'(n));
    check("R10 count at end", len_rd, 16'd0);
    check("R10 pointer at end", src_rd, end_src);
    e_mode = -1; e_len = 0;
  endtask

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy reset", busy, 1'b0);
    check("R1 requests reset", {host_req, vram_req}, 2'b00);
    check("R1 count reset", len_rd, 16'd0);
    check("R1 pointer reset", src_rd, 23'd0);
    rst_n = 1'b1;
    wreg(5'h13, 8'h03);
    cmd(6'h21, 16'h9000);
    repeat (3) @(posedge clk);
    #1;
    check("R3 disabled no start", busy, 1'b0);
    wreg(5'h01, 8'h10);
    cmd(6'h01, 16'h9000);
    repeat (3) @(posedge clk);
    #1;
    check("R3 no transfer bit no start", busy, 1'b0);
    check("R3 no writes", 32'(wr_idx), 0);

    run(0, 16'd5, 23'h7FFFFE, 16'h8100, 8'd1, 16'h0, 0);
    run(2, 16'd6, 23'h00FFFD, 16'h8200, 8'd2, 16'h0, 0);
    run(1, 16'd4, 23'h0, 16'h8300, 8'd3, 16'hBEEF, 1);
    for (int t = 0; t < 30; t++) begin
      int m = $urandom % 3;
      logic [15:0] l = 16'(1 + $urandom % 40);
      logic [22:0] s = (m == 0) ? 23'($urandom) : 23'($urandom % 32768);
      logic [15:0] d = 16'h8000 + 16'($urandom % 16'h7000);
      run(m, l, s, d, 8'($urandom % 5), 16'($urandom), t[0]);
    end
    run(1, 16'd0, 23'h0, 16'h9000, 8'd0, 16'h5A5A, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule